// File: doc/BRIEF.md
# Audio Stream Descriptor Register Bank

This block holds the host-visible configuration of one audio DMA stream in a high-definition-audio style controller. The host reaches it over a simple word-addressed register bus with byte-lane write strobes. Reads return one cycle after the address is presented. Each field applies its own mask on read and on write. Configuration writes are dropped without any error while the stream runs or while the controller is held in reset. Illegal FIFO codes are coerced to fixed defaults.

The bank also sequences the stream's own life cycle. It enters and leaves stream reset and keeps the run bit out of that state. On a start it issues a one-cycle fetch request for the current buffer descriptor before it enables the stream. It tracks the current descriptor index and wraps it at the last valid index. The DMA engine sees the values it needs directly as outputs: list base, buffer length, last index, format, FIFO byte counts and stream tag. The engine reports buffer-complete, FIFO-error and descriptor-error events, which set sticky status bits.

Top module: `sd_regbank`

## Requirements
- R1: After the synchronous reset every stored field reads zero, with two exceptions. The FIFO size code is 0xBF (fifo_bytes = 192). The watermark code is 4 on an input stream (fifow_bytes = 32) and 0 on an output stream (fifow_bytes = 0). stream_en and fetch_req are low.
- R2: Word index = byte offset / 4. The words are 0 control+status, 1 link position, 2 buffer length, 3 last index (bits 15:0) + watermark (bits 18:16), 4 FIFO size (bits 7:0) + format (bits 31:16), 5 reserved, 6 list base low, 7 list base high. rd_data shows the word selected by rd_word one clock later. Word 5 always reads 0, and writes to it have no effect.
- R3: Writes merge only the byte lanes whose wr_be bit is set. The following masks apply:
  - Control keeps bits 23:20 (stream tag) and 4:0, where bit 0 is stream reset, bit 1 is run and bits 4:2 are interrupt enables.
  - Last index keeps 16 bits.
  - Format keeps the bits in 0x7F7F.
  - List base low always reads bits 6:0 as zero.
  - Word 1 ignores writes and returns lpib_in.
- R4: While the run bit is set, writes to words 1-7 are dropped. Writes to word 0 are still accepted.
- R5: While ctl_reset is high, every write is dropped.
- R6: cur_idx returns to 0 on an accepted write that touches the buffer length, the last index (byte lanes 0-1 of word 3), or either list base word. While stream_en is high, desc_adv steps cur_idx, and the index wraps to 0 after it equals the last index.
- R7: On an input stream, a write of byte lane 2 of word 3 stores the watermark code if the byte is 2, 3 or 4. Any other value stores 4. Codes 2, 3 and 4 give fifow_bytes of 8, 16 and 32. On an output stream such writes are ignored.
- R8: A write of byte lane 0 of word 4 stores the FIFO size code if it is one of 0x0F, 0x1F, 0x3F, 0x7F, 0xBF or 0xFF. Any other value stores 0xBF. fifo_bytes = code + 1.
- R9: Setting the stream-reset bit takes effect only if run is currently clear. Entering stream reset clears cur_idx and the status bits. While stream reset is set, run is forced to 0. Writing the reset bit to 0 leaves stream reset.
- R10: A write that takes run from 0 to 1 raises fetch_req for exactly the next cycle, and stream_en rises one cycle after that. A write that clears run drops stream_en on the same edge.
- R11: Status bits 4:2 (word 0 bits 28:26) are set by evt_ioc, evt_fifo_err and evt_desc_err. Writing 1 to a status bit clears it, and an event in the same cycle wins. Status bit 5 (word 0 bit 29) reads stream_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reset | input | 1 | Controller-level reset active; blocks all writes |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 3 | Word index of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables of the write |
| rd_word | input | 3 | Word index to read |
| rd_data | output | 32 | Registered read data |
| lpib_in | input | 32 | Link position from the DMA side |
| evt_ioc | input | 1 | Buffer completion event |
| evt_fifo_err | input | 1 | FIFO error event |
| evt_desc_err | input | 1 | Descriptor error event |
| desc_adv | input | 1 | DMA moved to the next descriptor |
| bdl_base | output | 64 | Descriptor list base address |
| cbl | output | 32 | Cyclic buffer length |
| lvi | output | 16 | Last valid index |
| fmt | output | 16 | Stream format |
| fifo_bytes | output | 16 | Effective FIFO size in bytes |
| fifow_bytes | output | 16 | FIFO watermark in bytes |
| cur_idx | output | 8 | Current descriptor index |
| stream_tag | output | 4 | Stream tag from the control register |
| fetch_req | output | 1 | One-cycle request to fetch the current descriptor |
| stream_en | output | 1 | Stream enabled toward the DMA engine |

## Verification
The hardest states to reach from the ports come from collisions. One is an event that lands in the same cycle as a write-one-to-clear of the same status bit. Another is a stream-reset request written while run is already set, and a run request written while stream reset holds. The bench creates each of these by driving the write and the event in the same cycle, or by writing control bytes in a chosen order around a running stream. Writes under run and under controller reset are read back afterwards to show they were dropped. A fixed-seed random phase then mixes byte strobes across the configuration words and compares each readback against a bench model of the masks.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] W_CTL  = 3'd0;
  localparam logic [AW-1:0] W_LPIB = 3'd1;
  localparam logic [AW-1:0] W_CBL  = 3'd2;
  localparam logic [AW-1:0] W_LVI  = 3'd3;
  localparam logic [AW-1:0] W_FIFO = 3'd4;
  localparam logic [AW-1:0] W_BDL  = 3'd6;
  localparam logic [AW-1:0] W_BDU  = 3'd7;

  localparam logic [DW-1:0] CTL_WMASK = 32'h00F0001F;
  localparam logic [DW-1:0] BDL_WMASK = 32'hFFFFFF80;
  localparam logic [DW-1:0] LVI_WMASK = 32'h0000FFFF;
  localparam logic [DW-1:0] FMT_WMASK = 32'h7F7F0000;

  typedef struct packed {
    logic [3:0]  tag;
    logic [14:0] rsv;
    logic [2:0]  ien;
    logic        run;
    logic        srst;
  } ctl_t;

  // byte-lane merge, then keep non-writable bits from the old value
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd,
                                               input logic [BW-1:0] be,
                                               input logic [DW-1:0] wmask);
    logic [DW-1:0] res;
    res = old;
    for (int b = 0; b < BW; b++)
      if (be[b]) res[b*8 +: 8] = wd[b*8 +: 8];
    return (res & wmask) | (old & ~wmask);
  endfunction

  function automatic logic fifos_ok(input logic [7:0] c);
    return c inside {8'h0F, 8'h1F, 8'h3F, 8'h7F, 8'hBF, 8'hFF};
  endfunction

  function automatic logic fifow_ok(input logic [7:0] c);
    return c inside {8'h02, 8'h03, 8'h04};
  endfunction
endpackage

// File: rtl/sd_run_ctl.sv
module sd_run_ctl
  import sd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] be,
  output ctl_t          ctl_q,
  output logic          srst_enter,
  output logic          fetch_req,
  output logic          stream_en
);
  ctl_t          nxt;
  logic [DW-1:0] mrg;

  always_comb begin
    mrg        = lane_merge({8'h00, ctl_q}, wdata, be, CTL_WMASK);
    nxt        = ctl_q;
    srst_enter = 1'b0;
    if (we) begin
      nxt = ctl_t'(mrg[23:0]);
      if (!ctl_q.srst && nxt.srst) begin
        if (ctl_q.run) nxt.srst = 1'b0;
        else           srst_enter = 1'b1;
      end
      if (nxt.srst) nxt.run = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      fetch_req <= 1'b0;
      stream_en <= 1'b0;
    end else begin
      fetch_req <= we && !ctl_q.run && nxt.run;
      ctl_q     <= nxt;
      if (we && !nxt.run)  stream_en <= 1'b0;
      else if (fetch_req)  stream_en <= 1'b1;
    end
  end

  assert_en_after_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(stream_en) |-> $past(fetch_req));
  assert_en_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
    stream_en |-> ctl_q.run);
  assert_no_run_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q.srst |-> !ctl_q.run);
  assert_srst_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (we && ctl_q.run && !ctl_q.srst) |=> !ctl_q.srst);
endmodule

// File: rtl/sd_status.sv
module sd_status #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [NEV-1:0] w1c,
  input  logic [NEV-1:0] evt,
  input  logic           clr,
  output logic [NEV-1:0] sts_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) sts_q <= '0;
    else            sts_q <= (sts_q & ~(we ? w1c : '0)) | evt;
  end

  assert_evt_sets_R11: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((sts_q & $past(evt)) == $past(evt)));
  assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> ((sts_q & $past(w1c & ~evt)) == '0));
  assert_clr_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sts_q == '0));
endmodule

// File: rtl/sd_cfg.sv
module sd_cfg
  import sd_pkg::*;
#(
  parameter int         IDX_W     = 8,
  parameter bit         IS_INPUT  = 1'b1,
  parameter logic [7:0] FIFOS_DEF = 8'hBF,
  parameter logic [2:0] FIFOW_DEF = 3'd4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_cbl,
  input  logic             we_lvi,
  input  logic             we_fifo,
  input  logic             we_bdl,
  input  logic             we_bdu,
  input  logic [DW-1:0]    wdata,
  input  logic [BW-1:0]    be,
  input  logic             adv,
  input  logic             idx_clr,
  output logic [DW-1:0]    cbl_q,
  output logic [15:0]      lvi_q,
  output logic [15:0]      fmt_q,
  output logic [7:0]       fifos_q,
  output logic [2:0]       fifow_q,
  output logic [DW-1:0]    bdl_q,
  output logic [DW-1:0]    bdu_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [DW-1:0] m_lvi, m_fmt;
  logic          lvi_touch, idx_zero;

  assign m_lvi     = lane_merge({16'h0, lvi_q}, wdata, be, LVI_WMASK);
  assign m_fmt     = lane_merge({fmt_q, 16'h0}, wdata, be, FMT_WMASK);
  assign lvi_touch = we_lvi && |be[1:0];
  assign idx_zero  = we_cbl || lvi_touch || we_bdl || we_bdu || idx_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cbl_q   <= '0;
      lvi_q   <= '0;
      fmt_q   <= '0;
      fifos_q <= FIFOS_DEF;
      bdl_q   <= '0;
      bdu_q   <= '0;
      idx_q   <= '0;
    end else begin
      if (we_cbl) cbl_q <= lane_merge(cbl_q, wdata, be, '1);
      if (we_lvi) lvi_q <= m_lvi[15:0];
      if (we_fifo) fmt_q <= m_fmt[31:16];
      if (we_fifo && be[0])
        fifos_q <= fifos_ok(wdata[7:0]) ? wdata[7:0] : FIFOS_DEF;
      if (we_bdl) bdl_q <= lane_merge(bdl_q, wdata, be, BDL_WMASK);
      if (we_bdu) bdu_q <= lane_merge(bdu_q, wdata, be, '1);
      if (idx_zero)  idx_q <= '0;
      else if (adv)  idx_q <= (idx_q == lvi_q[IDX_W-1:0]) ? '0 : idx_q + 1'b1;
    end
  end

  generate
    if (IS_INPUT) begin : g_wm_in
      always_ff @(posedge clk) begin
        if (rst) fifow_q <= FIFOW_DEF;
        else if (we_lvi && be[2])
          fifow_q <= fifow_ok(wdata[23:16]) ? wdata[18:16] : FIFOW_DEF;
      end
    end else begin : g_wm_out
      assign fifow_q = 3'd0;
    end
  endgenerate

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
    idx_q <= lvi_q[IDX_W-1:0]);
  assert_idx_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (we_cbl || we_bdl || we_bdu) |=> (idx_q == '0));
  assert_bdl_align_R3: assert property (@(posedge clk) disable iff (rst)
    we_bdl |=> (bdl_q[6:0] == 7'd0));
endmodule

// File: rtl/sd_regbank.sv
module sd_regbank
  import sd_pkg::*;
#(
  parameter int         IDX_W     = 8,
  parameter bit         IS_INPUT  = 1'b1,
  parameter logic [7:0] FIFOS_DEF = 8'hBF,
  parameter logic [2:0] FIFOW_DEF = 3'd4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_reset,
  input  logic             wr_en,
  input  logic [2:0]       wr_word,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  input  logic [2:0]       rd_word,
  output logic [31:0]      rd_data,
  input  logic [31:0]      lpib_in,
  input  logic             evt_ioc,
  input  logic             evt_fifo_err,
  input  logic             evt_desc_err,
  input  logic             desc_adv,
  output logic [63:0]      bdl_base,
  output logic [31:0]      cbl,
  output logic [15:0]      lvi,
  output logic [15:0]      fmt,
  output logic [15:0]      fifo_bytes,
  output logic [15:0]      fifow_bytes,
  output logic [IDX_W-1:0] cur_idx,
  output logic [3:0]       stream_tag,
  output logic             fetch_req,
  output logic             stream_en
);
  ctl_t        ctl_q;
  logic        wr_ok, cfg_ok, srst_enter;
  logic [2:0]  sts_q;
  logic [7:0]  fifos_q;
  logic [2:0]  fifow_q;
  logic [31:0] bdl_q, bdu_q;
  logic [31:0] rd_mux;

  assign wr_ok  = wr_en && !ctl_reset;
  assign cfg_ok = wr_ok && !ctl_q.run;

  sd_run_ctl u_ctl (
    .clk(clk), .rst(rst), .we(wr_ok && (wr_word == W_CTL)),
    .wdata(wr_data), .be(wr_be), .ctl_q(ctl_q), .srst_enter(srst_enter),
    .fetch_req(fetch_req), .stream_en(stream_en)
  );

  sd_status #(.NEV(3)) u_sts (
    .clk(clk), .rst(rst), .we(wr_ok && (wr_word == W_CTL) && wr_be[3]),
    .w1c(wr_data[28:26]), .evt({evt_desc_err, evt_fifo_err, evt_ioc}),
    .clr(srst_enter), .sts_q(sts_q)
  );

  sd_cfg #(.IDX_W(IDX_W), .IS_INPUT(IS_INPUT), .FIFOS_DEF(FIFOS_DEF),
           .FIFOW_DEF(FIFOW_DEF)) u_cfg (
    .clk(clk), .rst(rst),
    .we_cbl (cfg_ok && (wr_word == W_CBL)),
    .we_lvi (cfg_ok && (wr_word == W_LVI)),
    .we_fifo(cfg_ok && (wr_word == W_FIFO)),
    .we_bdl (cfg_ok && (wr_word == W_BDL)),
    .we_bdu (cfg_ok && (wr_word == W_BDU)),
    .wdata(wr_data), .be(wr_be), .adv(desc_adv && stream_en),
    .idx_clr(srst_enter), .cbl_q(cbl), .lvi_q(lvi), .fmt_q(fmt),
    .fifos_q(fifos_q), .fifow_q(fifow_q), .bdl_q(bdl_q), .bdu_q(bdu_q),
    .idx_q(cur_idx)
  );

  assign bdl_base    = {bdu_q, bdl_q};
  assign stream_tag  = ctl_q.tag;
  assign fifo_bytes  = {8'h00, fifos_q} + 16'd1;
  assign fifow_bytes = (fifow_q == 3'd0) ? 16'd0 : (16'd1 << (fifow_q + 3'd1));

  always_comb begin
    case (rd_word)
      W_CTL:   rd_mux = {2'b00, stream_en, sts_q, 2'b00, ctl_q};
      W_LPIB:  rd_mux = lpib_in;
      W_CBL:   rd_mux = cbl;
      W_LVI:   rd_mux = {13'h0, fifow_q, lvi};
      W_FIFO:  rd_mux = {fmt, 8'h00, fifos_q};
      W_BDL:   rd_mux = bdl_q;
      W_BDU:   rd_mux = bdu_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assert_run_block_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_q.run && wr_word != W_CTL) |=>
      ($stable(cbl) && $stable(lvi) && $stable(fmt) && $stable(bdl_base)));
  assert_rst_block_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_reset) |=>
      ($stable(ctl_q) && $stable(cbl) && $stable(bdl_base) && $stable(fifo_bytes)));
endmodule

// File: tb/tb_sd_regbank.sv
`timescale 1ns/1ps
module tb_sd_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_word = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [2:0]  rd_word = '0;
  logic [31:0] rd_data, rd_out;
  logic [31:0] lpib_in = 32'hCAFE0001;
  logic        evt_ioc = 1'b0, evt_fifo_err = 1'b0, evt_desc_err = 1'b0;
  logic        desc_adv = 1'b0;
  logic [63:0] bdl_base, bdl_o;
  logic [31:0] cbl, cbl_o;
  logic [15:0] lvi, fmt, fifo_bytes, fifow_bytes, lvi_o, fmt_o, fb_o, fwb_o;
  logic [7:0]  cur_idx, idx_o;
  logic [3:0]  stream_tag, tag_o;
  logic        fetch_req, stream_en, fr_o, en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_regbank dut (
    .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .wr_be(wr_be), .rd_word(rd_word), .rd_data(rd_data),
    .lpib_in(lpib_in), .evt_ioc(evt_ioc), .evt_fifo_err(evt_fifo_err),
    .evt_desc_err(evt_desc_err), .desc_adv(desc_adv), .bdl_base(bdl_base),
    .cbl(cbl), .lvi(lvi), .fmt(fmt), .fifo_bytes(fifo_bytes),
    .fifow_bytes(fifow_bytes), .cur_idx(cur_idx), .stream_tag(stream_tag),
    .fetch_req(fetch_req), .stream_en(stream_en));

  sd_regbank #(.IS_INPUT(1'b0)) dut_out (
    .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .wr_be(wr_be), .rd_word(rd_word), .rd_data(rd_out),
    .lpib_in(lpib_in), .evt_ioc(evt_ioc), .evt_fifo_err(evt_fifo_err),
    .evt_desc_err(evt_desc_err), .desc_adv(desc_adv), .bdl_base(bdl_o),
    .cbl(cbl_o), .lvi(lvi_o), .fmt(fmt_o), .fifo_bytes(fb_o),
    .fifow_bytes(fwb_o), .cur_idx(idx_o), .stream_tag(tag_o),
    .fetch_req(fr_o), .stream_en(en_o));

  function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] be, input logic [31:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return (r & m) | (old & ~m);
  endfunction

  function automatic logic [31:0] wmask(input int w);
    case (w)
      3: return 32'h0000FFFF;
      4: return 32'h7F7F0000;
      6: return 32'hFFFFFF80;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] v);
    @(negedge clk);
    rd_word = w;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic adv();
    @(negedge clk); desc_adv = 1'b1;
    @(negedge clk); desc_adv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] model [8];
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd4, v);  chk("R1 fifo word", v, 32'h000000BF);
    chk("R1 fifo_bytes", fifo_bytes, 16'd192);
    chk("R1 fifow_bytes in", fifow_bytes, 16'd32);
    chk("R1 fifow_bytes out", fwb_o, 16'd0);
    rd(3'd0, v);  chk("R1 ctl word", v, 32'h0);
    chk("R1 stream_en/fetch", {stream_en, fetch_req}, 2'b00);

    // R3 masks and strobes, R2 map
    wr(3'd0, 32'h00FFFFFC, 4'b0111);
    rd(3'd0, v);  chk("R3 ctl mask", v, 32'h00F0001C);
    wr(3'd6, 32'hFFFFFFFF, 4'hF);
    rd(3'd6, v);  chk("R3 bdl low align", v, 32'hFFFFFF80);
    wr(3'd4, 32'hFFFF0000, 4'b1100);
    rd(3'd4, v);  chk("R3 fmt mask", v, 32'h7F7F00BF);
    wr(3'd3, 32'h00001234, 4'b0011);
    rd(3'd3, v);  chk("R3 lvi", v, 32'h00041234);
    wr(3'd1, 32'h0, 4'hF);
    rd(3'd1, v);  chk("R3 lpib read-only", v, 32'hCAFE0001);
    wr(3'd5, 32'hDEADBEEF, 4'hF);
    rd(3'd5, v);  chk("R2 reserved word", v, 32'h0);
    wr(3'd2, 32'h11223344, 4'hF);
    wr(3'd2, 32'hAABBCCDD, 4'b0100);
    rd(3'd2, v);  chk("R3 byte strobe", v, 32'h11BB3344);

    // R8 FIFO size
    wr(3'd4, 32'h0000003F, 4'b0001); chk("R8 legal 64", fifo_bytes, 16'd64);
    wr(3'd4, 32'h00000040, 4'b0001); chk("R8 illegal->192", fifo_bytes, 16'd192);
    wr(3'd4, 32'h000000FF, 4'b0001); chk("R8 legal 256", fifo_bytes, 16'd256);

    // R7 watermark
    wr(3'd3, 32'h00030000, 4'b0100); chk("R7 code3", fifow_bytes, 16'd16);
    wr(3'd3, 32'h00070000, 4'b0100); chk("R7 illegal->32", fifow_bytes, 16'd32);
    wr(3'd3, 32'h00020000, 4'b0100); chk("R7 code2", fifow_bytes, 16'd8);
    rd(3'd3, v);
    chk("R7 output stream ignores", {fwb_o, rd_out[18:16]}, {16'd0, 3'd0});

    // R10 start sequencing, R6 index
    wr(3'd3, 32'h00000003, 4'b0011);
    wr(3'd0, 32'h00000002, 4'b0001);
    chk("R10 fetch first", {fetch_req, stream_en}, 2'b10);
    @(negedge clk);
    chk("R10 enable next", {fetch_req, stream_en}, 2'b01);
    for (int i = 0; i < 4; i++) adv();
    chk("R6 wrap after lvi", cur_idx, 8'd0);
    adv();
    chk("R6 step", cur_idx, 8'd1);

    // R4 run gating
    wr(3'd2, 32'h00000055, 4'hF);
    wr(3'd3, 32'h00000000, 4'b0011);
    chk("R4 cbl/lvi/idx kept", {cbl, lvi, cur_idx}, {32'h11BB3344, 16'd3, 8'd1});
    wr(3'd0, 32'h00300000, 4'b0100);
    chk("R4 ctl writable", stream_tag, 4'd3);

    // R9 reset request while running
    wr(3'd0, 32'h00000003, 4'b0001);
    rd(3'd0, v);  chk("R9 srst blocked by run", v, 32'h20300002);

    // R11 status
    @(negedge clk); evt_ioc = 1'b1; @(negedge clk); evt_ioc = 1'b0;
    rd(3'd0, v);  chk("R11 event sets", v, 32'h24300002);
    wr(3'd0, 32'h04000000, 4'b1000);
    rd(3'd0, v);  chk("R11 w1c", v, 32'h20300002);
    @(negedge clk);
    wr_en = 1'b1; wr_word = 3'd0; wr_data = 32'h08000000; wr_be = 4'b1000;
    evt_fifo_err = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; evt_fifo_err = 1'b0;
    rd(3'd0, v);  chk("R11 set wins", v, 32'h28300002);

    // R10 stop
    wr(3'd0, 32'h00000000, 4'b0001);
    chk("R10 stop drops enable", {fetch_req, stream_en}, 2'b00);

    // R9 stream reset
    wr(3'd0, 32'h00000001, 4'b0001);
    rd(3'd0, v);  chk("R9 enter clears status", v, 32'h00300001);
    chk("R9 enter clears idx", cur_idx, 8'd0);
    wr(3'd0, 32'h00000003, 4'b0001);
    chk("R9 run forced off", fetch_req, 1'b0);
    rd(3'd0, v);  chk("R9 run stays 0", v, 32'h00300001);
    wr(3'd0, 32'h00000000, 4'b0001);
    rd(3'd0, v);  chk("R9 exit", v, 32'h00300000);

    // R6 index clear on length write
    wr(3'd0, 32'h00000002, 4'b0001);
    @(negedge clk);
    adv(); adv();
    chk("R6 idx before", cur_idx, 8'd2);
    wr(3'd0, 32'h00000000, 4'b0001);
    wr(3'd2, 32'h00000100, 4'hF);
    chk("R6 cbl write clears idx", cur_idx, 8'd0);

    // R5 controller reset
    ctl_reset = 1'b1;
    wr(3'd0, 32'h00000002, 4'b0001);
    chk("R5 no run start", fetch_req, 1'b0);
    wr(3'd2, 32'h00000077, 4'hF);
    ctl_reset = 1'b0;
    rd(3'd0, v);  chk("R5 ctl kept", v, 32'h00300000);
    rd(3'd2, v);  chk("R5 cbl kept", v, 32'h00000100);

    // random phase (R3 masks, R2 readback)
    foreach (model[i]) model[i] = '0;
    for (int w = 2; w < 8; w++) if (w != 5) begin
      rd(w[2:0], v); model[w] = v;
    end
    for (int i = 0; i < 40; i++) begin
      int          w;
      logic [31:0] d;
      logic [3:0]  be;
      case ($urandom % 5)
        0: w = 2; 1: w = 3; 2: w = 4; 3: w = 6; default: w = 7;
      endcase
      d  = $urandom;
      be = 4'($urandom);
      if (w == 3) be = be & 4'b0011;
      if (w == 4) be = be & 4'b1100;
      wr(w[2:0], d, be);
      model[w] = bmerge(model[w], d, be, wmask(w));
      rd(w[2:0], v);
      chk("R3 random readback", v, model[w]);
    end

    finish_run();
  end
endmodule